// File: doc/BRIEF.md
# Indirect Transfer FIFO and Status Flags

This block holds the data bytes of an indirect flash transfer between a byte-wide register port and the serial sequencer. When the controller writes to the flash, software pushes bytes through the register port and the sequencer drains them. When the controller reads from the flash, the sequencer fills the buffer and software pops the bytes through the same port. A single direction input decides which side pushes and which side pops.

The block also keeps the controller's status word and its interrupt line. The status word carries sticky event flags for error, completion, status match and timeout. It also carries a live threshold flag, a busy flag and the current fill level. Each sticky flag is cleared by writing a one to its bit of a separate flag-clear register. An abort input empties the buffer at once and ends the transaction.

Top module: `xfer_fifo_status`

## Requirements
- R1: After a synchronous reset with `dir_rd`=1, `status` is all zeros, `irq` is 0 and `reg_wait` is 0.
- R2: In write mode (`dir_rd`=0), bytes accepted at `reg_wdata` leave on `seq_out_data` in the same order, and `status[13:8]` gives the number of bytes held (0 to 32).
- R3: In read mode (`dir_rd`=1), bytes accepted from `seq_in_data` are returned on `reg_rdata` in the same order, one byte per `reg_rd` cycle.
- R4: With 32 bytes held in write mode, `reg_wr` raises `reg_wait` in the same cycle, and the byte is not stored. The level stays at 32.
- R5: With the buffer empty in read mode, `reg_rd` raises `reg_wait` in the same cycle, and the level stays at 0.
- R6: In read mode, `status[2]` is 1 exactly when the level is at least `thresh`+1.
- R7: In write mode, `status[2]` is 1 exactly when the free space (32 minus the level) is at least `thresh`+1.
- R8: A `seq_done` pulse sets `status[1]`. The bit stays set until a `clr_we` cycle with `clr_bits[1]`=1. A clear cycle with bit 1 at 0 leaves it set. If a set and a clear fall in the same cycle, the set wins.
- R9: `irq` is 1 whenever, for some i in 0..4, both `irq_en[i]` and `status[i]` are 1.
- R10: `status[5]` (busy) rises the cycle after `start`. It stays high while bytes remain, even after `seq_done`. It falls once completion has been seen and the buffer is empty.
- R11: One cycle after `abort`, the level is 0, busy is 0 and `seq_out_valid` is 0.
- R12: `ev_err`, `ev_match` and `ev_tmo` pulses set the sticky bits `status[0]`, `status[3]` and `status[4]`. Writing ones to the same bit positions of `clr_bits` clears them.
- R13: A port access against the direction has no effect. `reg_wr` in read mode stores nothing and does not wait. `reg_rd` in write mode pops nothing and returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_rd | input | 1 | 1 = read transfer (sequencer fills), 0 = write transfer (port fills) |
| thresh | input | 5 | Threshold setting; the flag needs thresh+1 bytes or slots |
| irq_en | input | 5 | Interrupt enables, bit i gates status bit i |
| start | input | 1 | Transaction start pulse |
| abort | input | 1 | Flush the buffer and end the transaction |
| reg_wr | input | 1 | Register port push request |
| reg_wdata | input | 8 | Register port push data |
| reg_rd | input | 1 | Register port pop request |
| reg_rdata | output | 8 | Popped byte, 0 when nothing is popped |
| reg_wait | output | 1 | Port stall: push while full or pop while empty |
| seq_in_valid | input | 1 | Sequencer byte offered (read mode) |
| seq_in_data | input | 8 | Sequencer byte |
| seq_in_ready | output | 1 | Buffer accepts the sequencer byte |
| seq_out_valid | output | 1 | Byte available to the sequencer (write mode) |
| seq_out_data | output | 8 | Byte toward the sequencer |
| seq_out_ready | input | 1 | Sequencer takes the byte |
| seq_done | input | 1 | Serial transfer finished pulse |
| ev_err | input | 1 | Transfer error event pulse |
| ev_match | input | 1 | Status match event pulse |
| ev_tmo | input | 1 | Timeout event pulse |
| clr_we | input | 1 | Flag-clear register write strobe |
| clr_bits | input | 5 | Write-one-to-clear mask, positions as in the status word |
| status | output | 16 | Flags in bits 5:0, level in bits 13:8 |
| irq | output | 1 | Interrupt line |

## Verification
In write mode, a full 32-byte burst with the drain held back shows that order is kept across pointer wrap. It also shows that a push at the full level stalls and does not overwrite. In read mode, the bytes come in from the sequencer side and are popped through the port, which exercises the opposite pairing of push and pop. The threshold flag is stepped across its exact edge in both directions: 3 against 4 bytes held, and 28 against 29 bytes held. An off-by-one or a swapped direction is therefore caught. Busy is checked with completion arriving while bytes remain, which separates the completion-only rule from the correct completion-and-empty rule. An abort issued in the middle of a transfer checks the flush.

// File: rtl/ifs_pkg.sv
package ifs_pkg;
  // status word bit positions (decoded by software)
  localparam int ST_ERR     = 0;
  localparam int ST_TC      = 1;
  localparam int ST_THR     = 2;
  localparam int ST_MATCH   = 3;
  localparam int ST_TMO     = 4;
  localparam int ST_BUSY    = 5;
  localparam int ST_LVL_LSB = 8;
  localparam int ST_W       = 16;
  localparam int NFLAG      = 5;
endpackage

// File: rtl/ifs_fifo.sv
// Byte buffer: distributed-RAM style storage, wrap pointers, fill level.
module ifs_fifo #(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_data;
  end

  assign head_data = mem[rptr];
  assign full      = (level == FULL_LVL);
  assign empty     = (level == '0);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push) wptr <= wptr + AW'(1);
      if (pop)  rptr <= rptr + AW'(1);
      case ({push, pop})
        2'b10:   level <= level + LW'(1);
        2'b01:   level <= level - LW'(1);
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/ifs_thresh.sv
// Threshold compare: bytes available (read) or slots free (write) vs thr+1.
module ifs_thresh #(
  parameter int DEPTH = 32,
  parameter int TW    = 5,
  localparam int LW   = $clog2(DEPTH) + 1,
  localparam int CW   = ((LW > TW) ? LW : TW) + 1
) (
  input  logic          dir_rd,
  input  logic [TW-1:0] thr,
  input  logic [LW-1:0] level,
  output logic          hit
);
  logic [CW-1:0] avail, need;

  always_comb begin
    avail = dir_rd ? CW'(level) : (CW'(DEPTH) - CW'(level));
    need  = CW'(thr) + CW'(1);
    hit   = (avail >= need);
  end
endmodule

// File: rtl/ifs_flags.sv
// Sticky event flags with write-one-to-clear, plus the busy tracker.
module ifs_flags #(
  parameter int NF = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          abort,
  input  logic          xfer_done,
  input  logic          fifo_empty,
  input  logic [NF-1:0] set_ev,
  input  logic          clr_we,
  input  logic [NF-1:0] clr_bits,
  output logic [NF-1:0] sticky,
  output logic          busy
);
  logic done_seen;

  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)            sticky[i] <= 1'b0;
      else if (set_ev[i]) sticky[i] <= 1'b1;   // set beats clear
      else if (clr_we && clr_bits[i]) sticky[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy      <= 1'b0;
      done_seen <= 1'b0;
    end else if (start) begin
      busy      <= 1'b1;
      done_seen <= 1'b0;
    end else if (busy && done_seen && fifo_empty) begin
      busy      <= 1'b0;
      done_seen <= 1'b0;
    end else begin
      done_seen <= done_seen | xfer_done;
    end
  end
endmodule

// File: rtl/xfer_fifo_status.sv
module xfer_fifo_status
  import ifs_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int DW    = 8,
  parameter int TW    = 5,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dir_rd,
  input  logic [TW-1:0]    thresh,
  input  logic [NFLAG-1:0] irq_en,
  input  logic             start,
  input  logic             abort,
  input  logic             reg_wr,
  input  logic [DW-1:0]    reg_wdata,
  input  logic             reg_rd,
  output logic [DW-1:0]    reg_rdata,
  output logic             reg_wait,
  input  logic             seq_in_valid,
  input  logic [DW-1:0]    seq_in_data,
  output logic             seq_in_ready,
  output logic             seq_out_valid,
  output logic [DW-1:0]    seq_out_data,
  input  logic             seq_out_ready,
  input  logic             seq_done,
  input  logic             ev_err,
  input  logic             ev_match,
  input  logic             ev_tmo,
  input  logic             clr_we,
  input  logic [NFLAG-1:0] clr_bits,
  output logic [ST_W-1:0]  status,
  output logic             irq
);
  logic          push, pop, full, empty, thr_hit, busy;
  logic [DW-1:0] push_data, head;
  logic [LW-1:0] level;
  logic [NFLAG-1:0] set_ev, sticky, flag_vec;
  logic          unused_thr_sticky;

  // direction steers which side fills and which side drains
  assign seq_in_ready  = dir_rd & ~full;
  assign seq_out_valid = ~dir_rd & ~empty;
  assign seq_out_data  = head;
  assign push      = dir_rd ? (seq_in_valid & ~full) : (reg_wr & ~full);
  assign push_data = dir_rd ? seq_in_data : reg_wdata;
  assign pop       = dir_rd ? (reg_rd & ~empty) : (seq_out_valid & seq_out_ready);
  assign reg_wait  = (reg_wr & ~dir_rd & full) | (reg_rd & dir_rd & empty);
  assign reg_rdata = (reg_rd & dir_rd & ~empty) ? head : '0;

  ifs_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk(clk), .rst(rst), .flush(abort), .push(push), .push_data(push_data),
    .pop(pop), .head_data(head), .level(level), .full(full), .empty(empty)
  );

  ifs_thresh #(.DEPTH(DEPTH), .TW(TW)) u_thr (
    .dir_rd(dir_rd), .thr(thresh), .level(level), .hit(thr_hit)
  );

  always_comb begin
    set_ev           = '0;
    set_ev[ST_ERR]   = ev_err;
    set_ev[ST_TC]    = seq_done;
    set_ev[ST_MATCH] = ev_match;
    set_ev[ST_TMO]   = ev_tmo;
  end

  ifs_flags #(.NF(NFLAG)) u_flags (
    .clk(clk), .rst(rst), .start(start), .abort(abort), .xfer_done(seq_done),
    .fifo_empty(empty), .set_ev(set_ev), .clr_we(clr_we), .clr_bits(clr_bits),
    .sticky(sticky), .busy(busy)
  );

  assign unused_thr_sticky = sticky[ST_THR];

  always_comb begin
    flag_vec         = sticky;
    flag_vec[ST_THR] = thr_hit;
    status           = '0;
    status[NFLAG-1:0]        = flag_vec;
    status[ST_BUSY]          = busy;
    status[ST_LVL_LSB +: LW] = level;
  end

  assign irq = |(flag_vec & irq_en);
endmodule

// File: rtl/ifs_chk.sv
module ifs_chk #(
  parameter int DEPTH = 32,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst,
  input logic          dir_rd,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic          reg_wait,
  input logic          seq_out_valid,
  input logic          seq_out_ready,
  input logic          abort,
  input logic          clr_we,
  input logic          clr_tc,
  input logic [LW-1:0] lvl,
  input logic          tc,
  input logic          busy
);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  assert_level_bound_R2: assert property (@(posedge clk) disable iff (rst)
    lvl <= FULL_LVL);

  assert_wait_full_R4: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !dir_rd && lvl == FULL_LVL) |-> reg_wait);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (lvl == FULL_LVL && !dir_rd && !(seq_out_valid && seq_out_ready) && !abort)
      |=> lvl == FULL_LVL);

  assert_wait_empty_R5: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && dir_rd && lvl == '0) |-> reg_wait);

  assert_tc_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (tc && !(clr_we && clr_tc)) |=> tc);

  assert_busy_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (busy && lvl != '0 && !abort) |=> busy);

  assert_abort_flush_R11: assert property (@(posedge clk) disable iff (rst)
    abort |=> (lvl == '0 && !busy));
endmodule

bind xfer_fifo_status ifs_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .dir_rd(dir_rd), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_wait(reg_wait), .seq_out_valid(seq_out_valid),
  .seq_out_ready(seq_out_ready), .abort(abort), .clr_we(clr_we),
  .clr_tc(clr_bits[1]), .lvl(status[8 +: LW]), .tc(status[1]),
  .busy(status[5])
);

// File: tb/xfer_fifo_status_test.sv
module xfer_fifo_status_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1;
  logic dir_rd = 1, start = 0, abort = 0;
  logic [4:0] thresh = 5'd3, irq_en = '0, clr_bits = '0;
  logic reg_wr = 0, reg_rd = 0, seq_in_valid = 0, seq_out_ready = 0;
  logic seq_done = 0, ev_err = 0, ev_match = 0, ev_tmo = 0, clr_we = 0;
  logic [7:0] reg_wdata = '0, seq_in_data = '0;
  logic [7:0] reg_rdata, seq_out_data;
  logic reg_wait, seq_in_ready, seq_out_valid, irq;
  logic [15:0] status;

  int checks = 0, fails = 0;
  logic [7:0] wq[$];
  logic [7:0] rq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  xfer_fifo_status uut (
    .clk(clk), .rst(rst), .dir_rd(dir_rd), .thresh(thresh), .irq_en(irq_en),
    .start(start), .abort(abort), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata), .reg_wait(reg_wait),
    .seq_in_valid(seq_in_valid), .seq_in_data(seq_in_data),
    .seq_in_ready(seq_in_ready), .seq_out_valid(seq_out_valid),
    .seq_out_data(seq_out_data), .seq_out_ready(seq_out_ready),
    .seq_done(seq_done), .ev_err(ev_err), .ev_match(ev_match), .ev_tmo(ev_tmo),
    .clr_we(clr_we), .clr_bits(clr_bits), .status(status), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int lvl();
    return int'(status[13:8]);
  endfunction

  // scoreboard monitors: compare bytes as the design hands them out
  always @(negedge clk) begin
    if (!rst && !dir_rd && seq_out_valid && seq_out_ready) begin
      if (wq.size() == 0) chk("R2 unexpected drain byte", int'(seq_out_data), -1);
      else chk("R2 drain order", int'(seq_out_data), int'(wq.pop_front()));
    end
    if (!rst && dir_rd && reg_rd && !reg_wait) begin
      if (rq.size() == 0) chk("R3 unexpected pop byte", int'(reg_rdata), -1);
      else chk("R3 pop order", int'(reg_rdata), int'(rq.pop_front()));
    end
  end

  task automatic tick_set();
    @(posedge clk); #1;
  endtask

  task automatic port_push(input logic [7:0] b);
    tick_set(); reg_wr = 1; reg_wdata = b; wq.push_back(b);
    tick_set(); reg_wr = 0;
  endtask

  task automatic seq_push(input logic [7:0] b);
    tick_set(); seq_in_valid = 1; seq_in_data = b; rq.push_back(b);
    tick_set(); seq_in_valid = 0;
  endtask

  task automatic port_pop();
    tick_set(); reg_rd = 1;
    tick_set(); reg_rd = 0;
  endtask

  task automatic clr_write(input logic [4:0] m);
    tick_set(); clr_we = 1; clr_bits = m;
    tick_set(); clr_we = 0; clr_bits = '0;
  endtask

  initial begin
    repeat (CLK_PERIOD * 0 + 200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1 rst = 0;
    @(negedge clk);
    chk("R1 status after reset", int'(status), 0);
    chk("R1 irq after reset", int'(irq), 0);
    chk("R1 wait after reset", int'(reg_wait), 0);

    // read mode: sequencer fills, port pops
    for (int i = 0; i < 3; i++) seq_push(8'h30 + 8'(i));
    @(negedge clk);
    chk("R6 level 3 thr 3 flag", int'(status[2]), 0);
    seq_push(8'h5C);
    @(negedge clk);
    chk("R6 level 4 thr 3 flag", int'(status[2]), 1);
    for (int i = 0; i < 4; i++) port_pop();
    @(negedge clk);
    chk("R3 level after pops", lvl(), 0);
    chk("R3 queue drained", rq.size(), 0);
    tick_set(); reg_rd = 1;
    @(negedge clk);
    chk("R5 wait on empty pop", int'(reg_wait), 1);
    tick_set(); reg_rd = 0;
    @(negedge clk);
    chk("R5 level stays 0", lvl(), 0);
    tick_set(); reg_wr = 1; reg_wdata = 8'hAA;
    @(negedge clk);
    chk("R13 no wait on read-mode write", int'(reg_wait), 0);
    tick_set(); reg_wr = 0;
    @(negedge clk);
    chk("R13 read-mode write stores nothing", lvl(), 0);

    // write mode: port fills, sequencer drains
    tick_set(); dir_rd = 0;
    @(negedge clk);
    chk("R7 empty write-mode flag", int'(status[2]), 1);
    for (int i = 0; i < 28; i++) port_push(8'(i * 7 + 1));
    @(negedge clk);
    chk("R2 level 28", lvl(), 28);
    chk("R7 free 4 thr 3 flag", int'(status[2]), 1);
    port_push(8'hE1);
    @(negedge clk);
    chk("R7 free 3 thr 3 flag", int'(status[2]), 0);
    for (int i = 0; i < 3; i++) port_push(8'hF0 + 8'(i));
    @(negedge clk);
    chk("R2 level full", lvl(), 32);
    tick_set(); reg_wr = 1; reg_wdata = 8'h99;
    @(negedge clk);
    chk("R4 wait on full push", int'(reg_wait), 1);
    tick_set(); reg_wr = 0;
    @(negedge clk);
    chk("R4 level stays 32", lvl(), 32);
    tick_set(); reg_rd = 1;
    @(negedge clk);
    chk("R13 write-mode read data", int'(reg_rdata), 0);
    tick_set(); reg_rd = 0;
    @(negedge clk);
    chk("R13 write-mode read pops nothing", lvl(), 32);
    tick_set(); seq_out_ready = 1;
    repeat (36) @(posedge clk);
    #1 seq_out_ready = 0;
    @(negedge clk);
    chk("R2 all bytes drained", wq.size(), 0);
    chk("R2 level after drain", lvl(), 0);

    // busy with completion arriving while bytes remain
    tick_set(); start = 1;
    tick_set(); start = 0;
    @(negedge clk);
    chk("R10 busy after start", int'(status[5]), 1);
    port_push(8'h11); port_push(8'h22);
    tick_set(); seq_done = 1;
    tick_set(); seq_done = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 busy held while bytes remain", int'(status[5]), 1);
    chk("R8 done sets complete flag", int'(status[1]), 1);
    tick_set(); seq_out_ready = 1;
    repeat (6) @(posedge clk);
    #1 seq_out_ready = 0;
    @(negedge clk);
    chk("R10 busy falls when done and empty", int'(status[5]), 0);

    // sticky completion flag and interrupt
    clr_write(5'b00000);
    @(negedge clk);
    chk("R8 clear without bit1 keeps flag", int'(status[1]), 1);
    tick_set(); irq_en = 5'b00010;
    @(negedge clk);
    chk("R9 irq from complete", int'(irq), 1);
    tick_set(); clr_we = 1; clr_bits = 5'b00010; seq_done = 1;
    tick_set(); clr_we = 0; clr_bits = '0; seq_done = 0;
    @(negedge clk);
    chk("R8 set wins over clear", int'(status[1]), 1);
    clr_write(5'b00010);
    @(negedge clk);
    chk("R8 write-one clears complete", int'(status[1]), 0);
    chk("R9 irq drops with flag", int'(irq), 0);
    tick_set(); irq_en = 5'b00100;
    @(negedge clk);
    chk("R9 irq from threshold", int'(irq), 1);
    tick_set(); irq_en = '0;

    // other sticky events
    tick_set(); ev_err = 1; ev_match = 1; ev_tmo = 1;
    tick_set(); ev_err = 0; ev_match = 0; ev_tmo = 0;
    @(negedge clk);
    chk("R12 event flags set", int'({status[4], status[3], status[0]}), 7);
    tick_set(); irq_en = 5'b00001;
    @(negedge clk);
    chk("R9 irq from error", int'(irq), 1);
    clr_write(5'b11001);
    @(negedge clk);
    chk("R12 event flags cleared", int'({status[4], status[3], status[0]}), 0);
    tick_set(); irq_en = '0;

    // abort mid transfer
    tick_set(); start = 1;
    tick_set(); start = 0;
    for (int i = 0; i < 5; i++) port_push(8'h60 + 8'(i));
    tick_set(); abort = 1; wq.delete();
    tick_set(); abort = 0;
    @(negedge clk);
    chk("R11 level after abort", lvl(), 0);
    chk("R11 busy after abort", int'(status[5]), 0);
    chk("R11 no drain byte after abort", int'(seq_out_valid), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule